// File: doc/BRIEF.md
# Packet Framing Engine

This block turns bytes from a host into one serial transmit frame. The host writes the payload byte count into a one-byte buffer first. The engine then sends a preamble of alternating ones and zeros, a sync word taken from a configuration word, and the payload bytes, which the host passes through the same buffer one at a time. Each symbol on the serial output is held for a fixed number of clock cycles. Payload bits can be Manchester encoded.

The host paces its writes from the buffer-full output `rdy`. This output rises when a write is accepted. It falls when the engine takes the byte. Each falling edge means the buffer can take the next byte, and that byte has to arrive before the engine needs it.

The frame can wait for amplifier and lock status before it starts. An amplifier-enable output rises when the count is written and, if chosen, drops the moment the last symbol ends. If a payload byte is missing when it is needed, the frame is aborted and an underrun flag is raised.

Top module: `pkt_framer`

## Requirements
- R1: After reset, `rdy`, `tx_active`, `tx_data`, `amp_en` and `underrun` are all 0.
- R2: The preamble is (`cfg_pre_len`+1) bytes of 0xAA.
- R3: After the preamble come (`cfg_sync_len`+1) sync bytes, taken from `cfg_sync_word` most significant byte first (bits 31:24 first, then 23:16, and so on).
- R4: A write accepted while idle is the payload byte count, which excludes preamble and sync. `tx_active` falls at the end of the last payload symbol. With a count of 0 it falls at the end of the last sync symbol.
- R5: Bytes are sent MSB first. Each symbol holds `tx_data` for CHIP_CYCLES clock cycles. `tx_data` is 0 while `tx_active` is 0.
- R6: With `cfg_manch_en`=1, each payload bit becomes two symbols: 1 is sent as 1 then 0, and 0 is sent as 0 then 1. Preamble and sync are never encoded.
- R7: `rdy` is high from the edge that accepts a write until the edge at which the engine takes the byte. A write while `rdy` is high is ignored.
- R8: With `cfg_lock_gate`=0, `tx_active` rises at the second clock edge after the edge that accepts the count, whatever `amp_on` and `lock_det` are. With `cfg_lock_gate`=1, it also waits until `amp_on` and `lock_det` are both high at an edge.
- R9: `amp_en` rises at the edge that accepts the count and stays high while a frame is sent. With `cfg_eof_cut`=1 it falls at the same edge as `tx_active`. With `cfg_eof_cut`=0 it stays high after the frame.
- R10: If a payload byte is needed and the buffer is empty, `underrun` rises and `tx_active` and `amp_en` fall at that byte boundary. The next count write clears `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pre_len | input | 2 | Preamble byte count minus one |
| cfg_sync_len | input | 2 | Sync byte count minus one |
| cfg_sync_word | input | 32 | Sync bytes, most significant sent first |
| cfg_manch_en | input | 1 | Manchester-encode payload |
| cfg_lock_gate | input | 1 | Wait for amplifier on and lock before start |
| cfg_eof_cut | input | 1 | Drop amplifier enable after last symbol |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Buffer write byte |
| amp_on | input | 1 | Amplifier is on |
| lock_det | input | 1 | Synthesizer lock detected |
| rdy | output | 1 | Buffer holds an unconsumed byte |
| tx_active | output | 1 | Frame symbols are being sent |
| tx_data | output | 1 | Serial symbol output |
| amp_en | output | 1 | Amplifier enable |
| underrun | output | 1 | Frame aborted for a missing byte |

## Verification
A wrong bit counter, byte counter or field selector shows up on `tx_data` within one symbol time. The bench checks every cycle of the frame, so one wrong symbol is caught. A wrong payload count or a bad finish decision moves the falling edge of `tx_active`, and the bench checks that edge to the exact cycle. A buffer flag that is set when it should be clear, or the reverse, has two effects. It shifts the `rdy` edges the host reacts to, and it either causes an underrun at the next byte boundary or lets an ignored write replace the payload byte that is sent.

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int CHIP_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_pre_len,
  input  logic [1:0]  cfg_sync_len,
  input  logic [31:0] cfg_sync_word,
  input  logic        cfg_manch_en,
  input  logic        cfg_lock_gate,
  input  logic        cfg_eof_cut,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        amp_on,
  input  logic        lock_det,
  output logic        rdy,
  output logic        tx_active,
  output logic        tx_data,
  output logic        amp_en,
  output logic        underrun
);
  localparam int CW = (CHIP_CYCLES > 1) ? $clog2(CHIP_CYCLES) : 1;
  localparam logic [CW-1:0] CLAST = CW'(CHIP_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ARM, S_PRE, S_SYNC, S_PAY} st_t;

  st_t         st;
  logic [7:0]  buf_q, sh, left;
  logic        buf_full, half, amp_q, und_q;
  logic [2:0]  bit_idx;
  logic [1:0]  fcnt;
  logic [CW-1:0] ccnt;

  function automatic logic [7:0] sync_byte(input logic [1:0] i);
    case (i)
      2'd0:    return cfg_sync_word[31:24];
      2'd1:    return cfg_sync_word[23:16];
      2'd2:    return cfg_sync_word[15:8];
      default: return cfg_sync_word[7:0];
    endcase
  endfunction

  wire act      = (st == S_PRE) || (st == S_SYNC) || (st == S_PAY);
  wire chip_end = act && (ccnt == CLAST);
  wire manch    = cfg_manch_en && (st == S_PAY);
  wire go       = !cfg_lock_gate || (amp_on && lock_det);
  wire wr_ok    = wr_en && !buf_full && (st == S_ARM || act);

  assign rdy       = buf_full;
  assign tx_active = act;
  assign tx_data   = act && (manch && half ? ~sh[7] : sh[7]);
  assign amp_en    = amp_q;
  assign underrun  = und_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; buf_q <= '0; sh <= '0; left <= '0; buf_full <= 1'b0;
      half <= 1'b0; amp_q <= 1'b0; und_q <= 1'b0; bit_idx <= '0; fcnt <= '0; ccnt <= '0;
    end else begin
      ccnt <= (act && !chip_end) ? ccnt + 1'b1 : '0;
      if (wr_ok) begin
        buf_q <= wr_data;
        buf_full <= 1'b1;
      end
      case (st)
        S_IDLE: if (wr_en) begin
          left <= wr_data; buf_full <= 1'b1; amp_q <= 1'b1; und_q <= 1'b0; st <= S_LOAD;
        end
        S_LOAD: begin
          buf_full <= 1'b0; st <= S_ARM;
        end
        S_ARM: if (go) begin
          st <= S_PRE; sh <= 8'hAA; bit_idx <= '0; half <= 1'b0; fcnt <= '0;
        end
        default: if (chip_end) begin
          if (manch && !half) begin
            half <= 1'b1;
          end else begin
            half <= 1'b0;
            if (bit_idx != 3'd7) begin
              sh <= {sh[6:0], 1'b0};
              bit_idx <= bit_idx + 1'b1;
            end else begin
              bit_idx <= '0;
              if (st == S_PRE) begin
                if (fcnt != cfg_pre_len) begin
                  fcnt <= fcnt + 1'b1; sh <= 8'hAA;
                end else begin
                  fcnt <= '0; st <= S_SYNC; sh <= sync_byte(2'd0);
                end
              end else if (st == S_SYNC && fcnt != cfg_sync_len) begin
                fcnt <= fcnt + 1'b1; sh <= sync_byte(fcnt + 1'b1);
              end else if ((st == S_SYNC && left == 8'd0) || (st == S_PAY && left == 8'd1)) begin
                st <= S_IDLE; buf_full <= 1'b0;
                if (cfg_eof_cut) amp_q <= 1'b0;
              end else begin
                if (st == S_PAY) left <= left - 1'b1;
                if (buf_full) begin
                  sh <= buf_q; buf_full <= 1'b0; st <= S_PAY;
                end else begin
                  und_q <= 1'b1; amp_q <= 1'b0; st <= S_IDLE;
                end
              end
            end
          end
        end
      endcase
    end
  end

  AST_LOCK_GATE:   assert property (@(posedge clk) disable iff (!rst_n)
                     $rose(tx_active) && cfg_lock_gate |-> $past(amp_on && lock_det)); // R8
  AST_EOF_CUT:     assert property (@(posedge clk) disable iff (!rst_n)
                     $fell(tx_active) && cfg_eof_cut |-> !amp_en); // R9
  AST_ACTIVE_AMP:  assert property (@(posedge clk) disable iff (!rst_n)
                     tx_active |-> amp_en); // R9
  AST_UNDER_STOP:  assert property (@(posedge clk) disable iff (!rst_n)
                     $rose(underrun) |-> !tx_active && !amp_en); // R10
  AST_CHIP_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                     tx_active && $past(tx_active) && ccnt != '0 |-> $stable(tx_data)); // R5
  AST_BUF_KEEP:    assert property (@(posedge clk) disable iff (!rst_n)
                     $past(rdy) && rdy |-> $stable(buf_q)); // R7
endmodule

// File: tb/tb_pkt_framer.sv
module tb_pkt_framer;
  localparam int CC = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_pre_len = '0, cfg_sync_len = '0;
  logic [31:0] cfg_sync_word = '0;
  logic cfg_manch_en = 0, cfg_lock_gate = 0, cfg_eof_cut = 0;
  logic wr_en = 0, amp_on = 0, lock_det = 0;
  logic [7:0] wr_data = '0;
  logic rdy, tx_active, tx_data, amp_en, underrun;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pkt_framer #(.CHIP_CYCLES(CC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_pre_len(cfg_pre_len), .cfg_sync_len(cfg_sync_len),
    .cfg_sync_word(cfg_sync_word), .cfg_manch_en(cfg_manch_en), .cfg_lock_gate(cfg_lock_gate),
    .cfg_eof_cut(cfg_eof_cut), .wr_en(wr_en), .wr_data(wr_data), .amp_on(amp_on),
    .lock_det(lock_det), .rdy(rdy), .tx_active(tx_active), .tx_data(tx_data),
    .amp_en(amp_en), .underrun(underrun));

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, a, e, $time);
    end
  endtask

  task automatic run_frame(input int pre, input int sync, input int plen, input bit manch,
                           input bit gate, input bit eof, input int skip, input bit dup,
                           input logic [31:0] sw);
    bit exp[$];
    logic [7:0] pay[$];
    logic [7:0] b;
    int start_t, end_t, k, c, nhead;
    bit abort, prev_rdy, wrote, dup_next;
    string tag;
    for (int i = 0; i < plen; i++) pay.push_back(8'(i * 73 + plen * 29 + 5));
    for (int i = 0; i <= pre; i++)
      for (int j = 7; j >= 0; j--) exp.push_back(j % 2 == 1);
    for (int i = 0; i <= sync; i++) begin
      b = sw[31 - 8*i -: 8];
      for (int j = 7; j >= 0; j--) exp.push_back(b[j]);
    end
    nhead = exp.size();
    for (int i = 0; i < plen; i++) begin
      if (i == skip) break;
      for (int j = 7; j >= 0; j--) begin
        exp.push_back(pay[i][j]);
        if (manch) exp.push_back(!pay[i][j]);
      end
    end
    abort = (skip >= 0) && (skip < plen);
    @(negedge clk);
    cfg_pre_len = 2'(pre); cfg_sync_len = 2'(sync); cfg_sync_word = sw;
    cfg_manch_en = manch; cfg_lock_gate = gate; cfg_eof_cut = eof;
    lock_det = 0; amp_on = 1; wr_en = 1; wr_data = 8'(plen);
    start_t = gate ? 9 : 3;
    end_t = start_t + exp.size() * CC;
    k = 0; prev_rdy = 0; wrote = 0; dup_next = 0;
    for (int t = 1; t <= end_t + 3; t++) begin
      @(negedge clk);
      if (t == 1) begin
        chk(rdy == 1, "R7 rdy after count write", rdy, 1);
        chk(underrun == 0, "R10 underrun cleared", underrun, 0);
        chk(amp_en == 1, "R9 amp_en on count write", amp_en, 1);
      end
      if (t < start_t) begin
        chk(tx_active == 0, "R8 start timing", tx_active, 0);
      end else if (t < end_t) begin
        c = (t - start_t) / CC;
        if (c < (pre + 1) * 8) tag = "R2 preamble";
        else if (c < nhead) tag = "R3 sync";
        else tag = manch ? "R6 manchester payload" : "R5 payload bits";
        chk(tx_active == 1, "R8 active during frame", tx_active, 1);
        chk(tx_data == exp[c], tag, tx_data, exp[c]);
        chk(amp_en == 1, "R9 amp on during frame", amp_en, 1);
      end else begin
        chk(tx_active == 0, "R4 frame end", tx_active, 0);
        chk(tx_data == 0, "R5 idle data", tx_data, 0);
        chk(amp_en == (!eof && !abort), "R9 amp after frame", amp_en, (!eof && !abort));
        chk(underrun == abort, "R10 underrun flag", underrun, abort);
      end
      if (wrote) chk(rdy == 1, "R7 rdy after write", rdy, 1);
      wr_en = 0; wrote = 0;
      if (dup_next) begin
        wr_en = 1; wr_data = ~pay[0]; dup_next = 0;
      end else if (prev_rdy && !rdy && k < plen && k != skip) begin
        wr_en = 1; wr_data = pay[k]; wrote = 1;
        if (dup && k == 0) dup_next = 1;
        k++;
      end
      prev_rdy = rdy;
      if (gate && t == 8) lock_det = 1;
    end
    wr_en = 0; lock_det = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdy == 0, "R1 reset rdy", rdy, 0);
    chk(tx_active == 0, "R1 reset tx_active", tx_active, 0);
    chk(tx_data == 0, "R1 reset tx_data", tx_data, 0);
    chk(amp_en == 0, "R1 reset amp_en", amp_en, 0);
    chk(underrun == 0, "R1 reset underrun", underrun, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_frame(0, 0, 2, 0, 0, 1, -1, 0, 32'hC35A1EF0);
    run_frame(3, 3, 3, 1, 0, 1, -1, 1, 32'h9D2B47E1);
    run_frame(1, 2, 0, 0, 0, 0, -1, 0, 32'h5F0C8A36);
    run_frame(2, 1, 2, 0, 1, 1, -1, 0, 32'hE4713BD2);
    run_frame(0, 1, 4, 0, 0, 1, 2, 0, 32'h2A96C05B);
    run_frame(1, 0, 1, 1, 0, 1, -1, 0, 32'h7BE31D48);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule